// File: doc/BRIEF.md
# Flag Offset Register Sequencer

This block keeps the four byte-wide threshold registers that a FIFO's almost-empty and almost-full flag logic compares against. Software or a host loads them one byte at a time through the FIFO's own data input. While a shared load strobe is held low, each enabled write-clock edge stores the input byte into the register that a rotating selection pointer names, and then advances the pointer. The same strobe, together with two read enables, lets the host read the registers back one byte per read-clock edge through an output register. The readback uses its own pointer, which follows the same rotation.

The pointers do not return to the first register when a load or readback is stopped part-way. The next access continues with the register after the last one used. This allows the host to update only one or two bytes without touching the rest. The two 16-bit thresholds are assembled from the byte pairs and driven continuously to the flag comparators. The FIFO storage and the comparators are outside this block. Loads and readbacks must never be issued in the same cycle.

Top module: `flag_offset_seq`

## Requirements
- R1: While `rst_n` is low, all registers take their defaults and `dout` is 0. With default parameters, `empty_ofs` and `full_ofs` both read 16'h0007.
- R2: On a `wr_clk` rising edge with `load_n` low and `wen_n` low, `din` is stored into the selected register and the write pointer advances by one. Only that one byte of the outputs changes.
- R3: The selection order is index 0 = empty low byte, 1 = empty high byte, 2 = full low byte, 3 = full high byte. `empty_ofs` = {byte1, byte0} and `full_ofs` = {byte3, byte2}.
- R4: After index 3, both the write pointer and the read pointer wrap to index 0.
- R5: When `load_n` is high, `wen_n` has no effect and the write pointer holds. A later load resumes at the next register, not at index 0.
- R6: When `load_n` is low and `wen_n` is high, no register changes and the write pointer does not advance.
- R7: On a `rd_clk` rising edge with `load_n`, `ren_a_n` and `ren_b_n` all low, `dout` takes the register named by the read pointer, and the read pointer advances in the R3 order.
- R8: If `ren_a_n`, `ren_b_n` or `load_n` is high at a `rd_clk` edge, `dout` holds its value and the read pointer does not advance.
- R9: Reset returns both the write pointer and the read pointer to index 0, wherever they were before.
- R10: The write pointer and the read pointer move independently. Loads do not move the readback position, and readbacks do not move the load position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Load-side clock |
| rd_clk | input | 1 | Readback-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| load_n | input | 1 | Active-low register access strobe, shared by both sides |
| wen_n | input | 1 | Active-low write enable |
| ren_a_n | input | 1 | First active-low read enable |
| ren_b_n | input | 1 | Second active-low read enable |
| din | input | BYTE_W | Byte to be loaded |
| dout | output | BYTE_W | Readback output register |
| empty_ofs | output | 2*BYTE_W | Assembled almost-empty threshold |
| full_ofs | output | 2*BYTE_W | Assembled almost-full threshold |

## Verification
A load shows up on `empty_ofs`/`full_ofs` after the first `wr_clk` rising edge at which it is enabled, because there is one register stage. A readback shows up on `dout` after the `rd_clk` rising edge at which it is enabled, also through one register. The bench changes its inputs on the falling edge of the clock in question. It compares the threshold outputs on the next falling edge, after the capture edge. A monitor checks `dout` 2 ns after every `rd_clk` rising edge. At that point it either takes the next expected byte from the scoreboard queue or, when no read was enabled at that edge, confirms that `dout` has not changed.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    localparam int unsigned OFS_NREG = 4;
    localparam int unsigned OFS_SEL_W = $clog2(OFS_NREG);

    // Fixed access order; flag logic relies on the byte pairing.
    typedef enum logic [OFS_SEL_W-1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } ofs_sel_e;

    function automatic ofs_sel_e sel_next(input ofs_sel_e cur);
        logic [OFS_SEL_W-1:0] inc;
        inc = cur + 1'b1;
        return (cur == SEL_F_HI) ? SEL_E_LO : ofs_sel_e'(inc);
    endfunction

endpackage

// File: rtl/ofs_ptr.sv
module ofs_ptr
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_sel_e sel_q
);

    typedef struct packed {
        ofs_sel_e sel;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (step) begin
            ptr_d.sel = sel_next(ptr_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '{sel: SEL_E_LO};
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign sel_q = ptr_q.sel;

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
    import ofs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter logic [OFS_NREG*BYTE_W-1:0] RST_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  ofs_sel_e                   sel,
    input  logic [BYTE_W-1:0]          din,
    output logic [OFS_NREG*BYTE_W-1:0] bytes_q
);

    typedef struct packed {
        logic [OFS_NREG-1:0][BYTE_W-1:0] b;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [OFS_NREG-1:0] hit;

    for (genvar g = 0; g < OFS_NREG; g++) begin : g_hit
        assign hit[g] = wr_en && (sel == ofs_sel_e'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < OFS_NREG; i++) begin
            if (hit[i]) begin
                bank_d.b[i] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= bank_t'(RST_VAL);
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bytes_q = bank_q;

endmodule

// File: rtl/ofs_rdport.sv
module ofs_rdport
    import ofs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  ofs_sel_e                   sel,
    input  logic [OFS_NREG*BYTE_W-1:0] bytes,
    output logic [BYTE_W-1:0]          dout_q
);

    typedef struct packed {
        logic [BYTE_W-1:0] dout;
    } rp_t;

    rp_t rp_d, rp_q;

    always_comb begin
        rp_d = rp_q;
        if (rd_en) begin
            rp_d.dout = bytes[sel*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign dout_q = rp_q.dout;

endmodule

// File: rtl/flag_offset_seq.sv
module flag_offset_seq
    import ofs_pkg::*;
#(
    parameter int unsigned BYTE_W    = 8,
    parameter logic [2*BYTE_W-1:0] DEF_EMPTY = 7,
    parameter logic [2*BYTE_W-1:0] DEF_FULL  = 7
) (
    input  logic                wr_clk,
    input  logic                rd_clk,
    input  logic                rst_n,
    input  logic                load_n,
    input  logic                wen_n,
    input  logic                ren_a_n,
    input  logic                ren_b_n,
    input  logic [BYTE_W-1:0]   din,
    output logic [BYTE_W-1:0]   dout,
    output logic [2*BYTE_W-1:0] empty_ofs,
    output logic [2*BYTE_W-1:0] full_ofs
);

    localparam int unsigned BANK_W = OFS_NREG * BYTE_W;
    localparam logic [BANK_W-1:0] BANK_RST = {DEF_FULL, DEF_EMPTY};

    logic              wr_step;
    logic              rd_step;
    ofs_sel_e          wsel;
    ofs_sel_e          rsel;
    logic [BANK_W-1:0] bank;

    assign wr_step = !load_n && !wen_n;
    assign rd_step = !load_n && !ren_a_n && !ren_b_n;

    ofs_ptr u_wptr (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .step  (wr_step),
        .sel_q (wsel)
    );

    ofs_ptr u_rptr (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .step  (rd_step),
        .sel_q (rsel)
    );

    ofs_bank #(
        .BYTE_W  (BYTE_W),
        .RST_VAL (BANK_RST)
    ) u_bank (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_step),
        .sel     (wsel),
        .din     (din),
        .bytes_q (bank)
    );

    ofs_rdport #(
        .BYTE_W (BYTE_W)
    ) u_rd (
        .clk    (rd_clk),
        .rst_n  (rst_n),
        .rd_en  (rd_step),
        .sel    (rsel),
        .bytes  (bank),
        .dout_q (dout)
    );

    assign empty_ofs = bank[2*BYTE_W-1:0];
    assign full_ofs  = bank[4*BYTE_W-1:2*BYTE_W];

endmodule

// File: rtl/flag_offset_seq_chk.sv
module flag_offset_seq_chk #(
    parameter int unsigned BYTE_W    = 8,
    parameter logic [2*BYTE_W-1:0] DEF_EMPTY = 7,
    parameter logic [2*BYTE_W-1:0] DEF_FULL  = 7
) (
    input logic                wr_clk,
    input logic                rd_clk,
    input logic                rst_n,
    input logic                load_n,
    input logic                wen_n,
    input logic                ren_a_n,
    input logic                ren_b_n,
    input logic [BYTE_W-1:0]   din,
    input logic [BYTE_W-1:0]   dout,
    input logic [2*BYTE_W-1:0] empty_ofs,
    input logic [2*BYTE_W-1:0] full_ofs
);

    logic wstep, rstep;
    logic [4*BYTE_W-1:0] all_b;
    logic [4*BYTE_W-1:0] prev_b;
    logic [3:0] chg;

    assign wstep = !load_n && !wen_n;
    assign rstep = !load_n && !ren_a_n && !ren_b_n;
    assign all_b = {full_ofs, empty_ofs};

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) prev_b <= {DEF_FULL, DEF_EMPTY};
        else        prev_b <= all_b;
    end

    for (genvar g = 0; g < 4; g++) begin : g_chg
        assign chg[g] = all_b[g*BYTE_W +: BYTE_W] != prev_b[g*BYTE_W +: BYTE_W];
    end

    // R1: defaults visible at the first edge after reset release
    p_reset_vals_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty_ofs == DEF_EMPTY && full_ofs == DEF_FULL));

    p_reset_dout_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout == '0));

    // R2: a load alters at most one byte, and the stored byte is din
    p_one_byte_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wstep |=> ($countones(chg) <= 1));

    p_data_lands_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wstep |=> (empty_ofs[BYTE_W-1:0] == $past(din) ||
                   empty_ofs[2*BYTE_W-1:BYTE_W] == $past(din) ||
                   full_ofs[BYTE_W-1:0] == $past(din) ||
                   full_ofs[2*BYTE_W-1:BYTE_W] == $past(din)));

    // R5, R6: no enabled load means thresholds hold
    p_no_load_hold_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wstep |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R8: readback output holds without a full read enable
    p_rd_hold_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rstep |=> $stable(dout));

    // R7: a readback presents one of the stored bytes
    p_rd_src_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rstep |=> (dout == empty_ofs[BYTE_W-1:0] ||
                   dout == empty_ofs[2*BYTE_W-1:BYTE_W] ||
                   dout == full_ofs[BYTE_W-1:0] ||
                   dout == full_ofs[2*BYTE_W-1:BYTE_W]));

endmodule

bind flag_offset_seq flag_offset_seq_chk #(
    .BYTE_W    (BYTE_W),
    .DEF_EMPTY (DEF_EMPTY),
    .DEF_FULL  (DEF_FULL)
) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .wen_n     (wen_n),
    .ren_a_n   (ren_a_n),
    .ren_b_n   (ren_b_n),
    .din       (din),
    .dout      (dout),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
);

// File: tb/sim_flag_offset_seq.sv
module sim_flag_offset_seq;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst_n  = 1'b0;
    logic       load_n = 1'b1;
    logic       wen_n  = 1'b1;
    logic       ren_a_n = 1'b1;
    logic       ren_b_n = 1'b1;
    logic [7:0] din    = 8'h00;
    logic [7:0]  dout;
    logic [15:0] empty_ofs;
    logic [15:0] full_ofs;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0] m_reg [4];
    int         m_wp;
    int         m_rp;
    logic [7:0] exp_q [$];
    logic [7:0] m_prev = 8'h00;
    logic       mon_step;

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    flag_offset_seq u0 (
        .wr_clk    (wr_clk),
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wen_n     (wen_n),
        .ren_a_n   (ren_a_n),
        .ren_b_n   (ren_b_n),
        .din       (din),
        .dout      (dout),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ofs(input string tag);
        chk({tag, " empty_ofs"}, {16'h0, empty_ofs}, {16'h0, m_reg[1], m_reg[0]});
        chk({tag, " full_ofs"},  {16'h0, full_ofs},  {16'h0, m_reg[3], m_reg[2]});
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst_n = 1'b0;
        m_reg[0] = 8'h07; m_reg[1] = 8'h00;
        m_reg[2] = 8'h07; m_reg[3] = 8'h00;
        m_wp = 0;
        m_rp = 0;
        repeat (2) @(negedge wr_clk);
        rst_n = 1'b1;
        @(negedge wr_clk);
    endtask

    // Load-side driver: changes inputs on the falling edge, model follows R2..R6
    task automatic wr_op(input logic ld, input logic we, input logic [7:0] d);
        @(negedge wr_clk);
        load_n = ld; wen_n = we; din = d;
        @(posedge wr_clk);
        if (!ld && !we) begin
            m_reg[m_wp] = d;
            m_wp = (m_wp + 1) % 4;
        end
        @(negedge wr_clk);
        load_n = 1'b1; wen_n = 1'b1;
    endtask

    // Readback driver: pushes the expected byte when a read is enabled (R7, R8)
    task automatic rd_op(input logic ld, input logic ra, input logic rb);
        @(negedge rd_clk);
        load_n = ld; ren_a_n = ra; ren_b_n = rb;
        if (!ld && !ra && !rb) begin
            exp_q.push_back(m_reg[m_rp]);
            m_rp = (m_rp + 1) % 4;
        end
        @(posedge rd_clk);
        @(negedge rd_clk);
        load_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1;
    endtask

    // Monitor: compares dout 2 ns after each rd_clk rising edge
    always @(posedge rd_clk) begin
        mon_step = !load_n && !ren_a_n && !ren_b_n;
        #2;
        if (rst_n && !done) begin
            if (mon_step) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected read", 32'd1, 32'd0);
                end else begin
                    chk("R7 readback byte", {24'h0, dout}, {24'h0, exp_q.pop_front()});
                end
            end else begin
                chk("R8 dout holds", {24'h0, dout}, {24'h0, m_prev});
            end
        end
        m_prev = dout;
    end

    initial begin
        repeat (20000) @(posedge wr_clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        // R1, R9: defaults and zero readback register
        chk_ofs("R1 reset");
        chk("R1 dout reset", {24'h0, dout}, 32'h0);

        // R2, R3: four loads in order
        wr_op(1'b0, 1'b0, 8'h11);
        chk_ofs("R3 after empty lo");
        wr_op(1'b0, 1'b0, 8'h22);
        wr_op(1'b0, 1'b0, 8'h33);
        wr_op(1'b0, 1'b0, 8'h44);
        chk_ofs("R2 R3 all four");
        // R4: wrap to empty low
        wr_op(1'b0, 1'b0, 8'h55);
        chk_ofs("R4 wrap");
        // R6: write enable high is ignored, pointer stays
        wr_op(1'b0, 1'b1, 8'hAA);
        chk_ofs("R6 no write");
        wr_op(1'b0, 1'b0, 8'h66);
        chk_ofs("R6 pointer held");
        // R5: load high ignored, next load resumes at full lo
        wr_op(1'b1, 1'b0, 8'hBB);
        chk_ofs("R5 no write");
        wr_op(1'b0, 1'b0, 8'h77);
        chk_ofs("R5 resume");

        // R7, R10: readback starts at index 0 regardless of load pointer
        rd_op(1'b0, 1'b0, 1'b0);
        rd_op(1'b0, 1'b1, 1'b0);
        rd_op(1'b0, 1'b0, 1'b1);
        rd_op(1'b1, 1'b0, 1'b0);
        rd_op(1'b0, 1'b0, 1'b0);
        rd_op(1'b0, 1'b0, 1'b0);
        rd_op(1'b0, 1'b0, 1'b0);
        rd_op(1'b0, 1'b0, 1'b0);
        rd_op(1'b0, 1'b0, 1'b0);
        // R10: readbacks did not move the load pointer (next is full hi)
        wr_op(1'b0, 1'b0, 8'hC3);
        chk_ofs("R10 load position kept");
        rd_op(1'b0, 1'b0, 1'b0);

        // R9: reset mid-sequence returns both pointers to index 0
        do_reset();
        chk_ofs("R9 R1 reset again");
        chk("R9 dout cleared", {24'h0, dout}, 32'h0);
        wr_op(1'b0, 1'b0, 8'h99);
        chk_ofs("R9 load at index 0");
        rd_op(1'b0, 1'b0, 1'b0);
        rd_op(1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge rd_clk);
        chk("R7 scoreboard drained", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule